// File: doc/BRIEF.md
# Network Status LED Driver with Pulse Stretching

This block turns a handful of network status indications into one active-low LED pin. A 16-bit configuration word selects which indications light the LED and whether short indications are stretched so that an eye can see them. The indications are collision, jabber, receive activity, receive polarity correct and transmit activity. Each may be a single-cycle pulse or a level. The enabled indications are ORed together.

With stretching off, the pin follows the combined OR in the same cycle. With stretching on, any active cycle loads a 3-bit shift register with all ones. An internal divider produces a one-cycle tick every `TICK_DIV` clocks, and each tick shifts a zero in. The LED stays lit while the OR is active or the register's top bit is set. A one-cycle event therefore remains visible for two to three tick periods. Software writes the word through a plain write strobe and reads it back at any time. A chip instantiates one copy per LED pin and gives each copy its own reset default.

Top module: `led_status_drv`

## Requirements
- R1: After reset, `cfg_rdata` equals the parameter `RST_VAL` with reserved bits cleared (0x0084 by default).
- R2: A cycle with `cfg_we` high stores `cfg_wdata` from the next cycle on. Only bits 0–4 and 7 are kept. Bits 6–5 and 15–8 always read as 0.
- R3: With bit 7 clear, `led_n` is the inverse of the OR of all enabled indications, in the same cycle as the inputs.
- R4: The enable bits are position-fixed: bit 0 collision, bit 1 jabber, bit 2 receive activity, bit 3 receive polarity correct, bit 4 transmit activity.
- R5: An indication whose enable bit is 0 has no effect on `led_n`, including when only reserved bits are set.
- R6: The polarity source lights the LED while `evt_rxpol_ok` is high (polarity correct) and not while it is low (polarity reversed).
- R7: With bit 7 set, one cycle of an enabled indication lights the LED at once. The LED then stays lit for between 2·TICK_DIV+1 and 3·TICK_DIV clock cycles after that cycle.
- R8: With bit 7 set, an indication held active keeps the LED lit without a gap. The stretch window counts from its last active cycle.
- R9: Clearing bit 7 discards any stretch in progress: `led_n` follows the OR directly from the next cycle. Setting bit 7 again with no active indication leaves the LED dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current configuration word |
| evt_col | input | 1 | Collision indication |
| evt_jab | input | 1 | Jabber indication |
| evt_rcv | input | 1 | Receive activity indication |
| evt_rxpol_ok | input | 1 | High while receive polarity is correct |
| evt_xmt | input | 1 | Transmit activity indication |
| led_n | output | 1 | LED pin, low means lit |

## Verification
Two functions can fall in the same cycle, and the bench provokes both. The first is a configuration write and the end of a stretched pulse. The bench drops the collision input in the same cycle that it clears the stretch bit. It then judges that the LED goes dark one cycle later instead of running out its window. The second is an active indication and a divider tick. The bench holds collision across several tick periods, then judges that the LED never blinks and that the window measured after release still falls inside the R7 bounds. This shows that a reload wins over a shift.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  localparam int CFG_W   = 16;
  localparam int NSRC    = 5;
  localparam int BIT_COL = 0;
  localparam int BIT_JAB = 1;
  localparam int BIT_RCV = 2;
  localparam int BIT_POL = 3;
  localparam int BIT_XMT = 4;
  localparam int BIT_STR = 7;
  localparam logic [CFG_W-1:0] CFG_MASK = 16'h009F;

  typedef struct packed {
    logic xmt;
    logic pol;
    logic rcv;
    logic jab;
    logic col;
  } led_evt_t;
endpackage

// File: rtl/led_cfg_reg.sv
module led_cfg_reg
  import led_drv_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_VAL = 16'h0084
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= RST_VAL & CFG_MASK;
    else if (we) q <= wdata & CFG_MASK;
  end

  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == ($past(wdata) & CFG_MASK))); // R2
endmodule

// File: rtl/led_src_mux.sv
module led_src_mux
  import led_drv_pkg::*;
(
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] en,
  output logic            hit
);
  logic [NSRC-1:0] gated;

  for (genvar i = 0; i < NSRC; i++) begin : g_gate
    assign gated[i] = evt[i] & en[i];
  end

  assign hit = |gated;
endmodule

// File: rtl/led_tick_div.sv
module led_tick_div #(
  parameter int DIV = 2000000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  if (DIV <= 1) begin : g_pass
    assign tick = 1'b1;
  end else begin : g_cnt
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (!rst_n)           cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R7
  end
endmodule

// File: rtl/led_stretch.sv
module led_stretch #(
  parameter int SR_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  logic tick,
  output logic lit
);
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) sr <= '0;
    else if (hit)      sr <= '1;
    else if (tick)     sr <= {sr[SR_W-2:0], 1'b0};
  end

  assign lit = en ? (hit | sr[SR_W-1]) : hit;

  AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en && hit)) |-> lit); // R8
  AST_DIRECT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (lit == hit)); // R9
endmodule

// File: rtl/led_status_drv.sv
module led_status_drv
  import led_drv_pkg::*;
#(
  parameter logic [15:0] RST_VAL  = 16'h0084,
  parameter int          TICK_DIV = 2000000,
  parameter int          SR_W     = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        evt_col,
  input  logic        evt_jab,
  input  logic        evt_rcv,
  input  logic        evt_rxpol_ok,
  input  logic        evt_xmt,
  output logic        led_n
);
  led_evt_t evt;
  logic     hit, tick, lit;

  assign evt = '{xmt: evt_xmt, pol: evt_rxpol_ok, rcv: evt_rcv,
                 jab: evt_jab, col: evt_col};

  led_cfg_reg #(.RST_VAL(RST_VAL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_rdata));

  led_src_mux u_mux (
    .evt(evt), .en(cfg_rdata[NSRC-1:0]), .hit(hit));

  led_tick_div #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  led_stretch #(.SR_W(SR_W)) u_str (
    .clk(clk), .rst_n(rst_n), .en(cfg_rdata[BIT_STR]), .hit(hit),
    .tick(tick), .lit(lit));

  assign led_n = ~lit;

  AST_DARK_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[NSRC-1:0] == '0 && !cfg_rdata[BIT_STR]) |-> led_n); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[15:8] == 8'h00) && (cfg_rdata[6:5] == 2'b00)); // R2
  AST_FAST_LIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_col && cfg_rdata[BIT_COL]) |-> !led_n); // R4
endmodule

// File: tb/tb_led_status_drv.sv
module tb_led_status_drv;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        evt_col = 0, evt_jab = 0, evt_rcv = 0, evt_rxpol_ok = 0, evt_xmt = 0;
  logic        led_n;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  led_status_drv #(.RST_VAL(16'h0084), .TICK_DIV(D), .SR_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .evt_col(evt_col), .evt_jab(evt_jab),
    .evt_rcv(evt_rcv), .evt_rxpol_ok(evt_rxpol_ok), .evt_xmt(evt_xmt),
    .led_n(led_n));

  // {cfg[7:0], evt{xmt,pol,rcv,jab,col}, expected led_n}
  localparam logic [13:0] VEC [12] = '{
    {8'h01, 5'h01, 1'b0},   // R4 collision
    {8'h01, 5'h1E, 1'b1},   // R5 others masked
    {8'h02, 5'h02, 1'b0},   // R4 jabber
    {8'h04, 5'h04, 1'b0},   // R4 receive
    {8'h08, 5'h08, 1'b0},   // R6 polarity correct
    {8'h08, 5'h00, 1'b1},   // R6 polarity reversed
    {8'h10, 5'h10, 1'b0},   // R4 transmit
    {8'h10, 5'h0F, 1'b1},   // R5
    {8'h1F, 5'h00, 1'b1},   // R3 nothing active
    {8'h1F, 5'h11, 1'b0},   // R3 OR of two
    {8'h00, 5'h1F, 1'b1},   // R5 none enabled
    {8'h60, 5'h1F, 1'b1}    // R5 reserved bits only
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_evt(input logic [4:0] e);
    {evt_xmt, evt_rxpol_ok, evt_rcv, evt_jab, evt_col} = e;
  endtask

  task automatic count_lit(output int n);
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if (led_n) break;
      n++;
      @(negedge clk); #1;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    bit all_lit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cfg_rdata == 16'h0084, "R1", cfg_rdata, 16'h0084);
    chk(led_n == 1'b1, "R1", led_n, 1);

    wr(16'hFFFF); #1;
    chk(cfg_rdata == 16'h009F, "R2", cfg_rdata, 16'h009F);
    wr(16'h0060); #1;
    chk(cfg_rdata == 16'h0000, "R2", cfg_rdata, 16'h0000);

    for (int i = 0; i < 12; i++) begin
      set_evt(5'h00);
      wr({8'h00, VEC[i][13:6]});
      set_evt(VEC[i][5:1]);
      #1;
      chk(led_n == VEC[i][0], "R3", led_n, VEC[i][0]);
    end

    // R7 single-cycle event stretched
    set_evt(5'h00);
    wr(16'h0081);
    repeat (20) @(negedge clk);
    evt_col = 1'b1; #1;
    chk(led_n == 1'b0, "R7", led_n, 0);
    @(negedge clk); evt_col = 1'b0; #1;
    count_lit(n);
    chk(n >= 2*D+1 && n <= 3*D, "R7", n, 3*D);

    // R8 held event across several ticks, then release
    repeat (5) @(negedge clk);
    evt_col = 1'b1;
    all_lit = 1;
    for (int i = 0; i < 5*D; i++) begin
      @(negedge clk); #1;
      if (led_n) all_lit = 0;
    end
    chk(all_lit, "R8", all_lit, 1);
    evt_col = 1'b0; #1;
    count_lit(n);
    chk(n >= 2*D+1 && n <= 3*D, "R8", n, 3*D);

    // R9 clear stretch bit in the same cycle the event ends
    repeat (5) @(negedge clk);
    evt_col = 1'b1;
    @(negedge clk);
    evt_col = 1'b0; cfg_we = 1'b1; cfg_wdata = 16'h0001;
    @(negedge clk);
    cfg_we = 1'b0; #1;
    chk(led_n == 1'b1, "R9", led_n, 1);
    wr(16'h0081); #1;
    chk(led_n == 1'b1, "R9", led_n, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule